// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a configurable AND plane feeding a fixed OR plane. Ten dedicated input signals and eight feedback signals are each split into a true line and a complement line, which gives 36 array lines. Each of 113 product-term rows holds one connection bit per line. A row evaluates as the AND of every line it connects. Of these rows, 102 are split unevenly across eight OR outputs. The remaining rows drive eight per-output enable terms and three global terms: a synchronous preset, an asynchronous clear and a clock term.

The connection pattern sits in on-chip storage. It is written one 36-bit row at a time through an address, a data word and a write strobe. A single-cycle erase command opens every connection in the array. Everything from the signal inputs and the stored pattern to the outputs is combinational. The macrocell flip-flops, the polarity control and the pin drivers that consume these terms sit outside the block.

Top module: `sop_array`

## Requirements
- R1: Array line 2k carries signal k and line 2k+1 carries its inverse. Signals 0 to 9 are `ded_i[0..9]` and signals 10 to 17 are `fb_i[0..7]`. Row bit n is the connection bit of line n.
- R2: A row bit of 1 connects its line. A row evaluates true exactly when every connected line is high.
- R3: A row with no connected lines always evaluates true, whatever the inputs are.
- R4: A row that connects both lines of the same signal always evaluates false.
- R5: `sum_o[j]` is the OR of a contiguous run of rows. Runs start at row 0, follow one another in output order and have sizes 8, 10, 12, 14, 16, 16, 14, 12 for j = 0 to 7. This uses rows 0 to 101.
- R6: Rows 102+j drive `oe_o[j]`. Row 110 drives `preset_o`, row 111 drives `clear_o` and row 112 drives `clock_o`.
- R7: When `wr_en_i` is high at a rising clock edge, row `wr_addr_i` takes `wr_row_i`. The outputs reflect the new row once that edge has passed.
- R8: A write to an address of 113 or above changes no stored row.
- R9: When `erase_i` is high at a rising clock edge, every row is cleared to 0 (unconnected). Erase wins over a write in the same cycle.
- R10: While `rst_ni` is low, the storage is held erased, so every output reads 1.
- R11: The outputs follow input changes without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for pattern writes and erase |
| rst_ni | input | 1 | Active-low asynchronous reset; erases storage |
| ded_i | input | 10 | Dedicated input signals |
| fb_i | input | 8 | Feedback or I/O input signals |
| wr_en_i | input | 1 | Row write strobe |
| wr_addr_i | input | 7 | Row address of the write |
| wr_row_i | input | 36 | Connection bits of the row being written |
| erase_i | input | 1 | Bulk erase command |
| sum_o | output | 8 | OR-plane outputs |
| oe_o | output | 8 | Output-enable terms |
| preset_o | output | 1 | Global synchronous preset term |
| clear_o | output | 1 | Global asynchronous clear term |
| clock_o | output | 1 | Programmable clock term |

## Verification
There are two kinds of result. A write or erase takes effect at the single rising edge on which it is presented, and the outputs carry the new pattern for the rest of that cycle. The bench therefore drives these commands on a falling edge and reads the outputs on the next falling edge. Signal-input changes pass through no register. The bench changes them between edges and reads a short delay later, with no clock edge in between, which shows that nothing is latched. Each group and control row is isolated by first writing every row to an always-false pattern, so any stray mapping shows up as an extra or missing bit.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int N_OUT    = 8;
  localparam int N_SUM    = 102;
  localparam int N_GLOBAL = 3;
  localparam int N_CTL    = N_OUT + N_GLOBAL;
  localparam int N_TERM   = N_SUM + N_CTL;
  localparam int ROW_OE   = N_SUM;
  localparam int ROW_PRE  = N_SUM + N_OUT;
  localparam int ROW_CLR  = ROW_PRE + 1;
  localparam int ROW_CLK  = ROW_PRE + 2;

  function automatic int grp_size(int j);
    case (j)
      0: return 8;
      1: return 10;
      2: return 12;
      3: return 14;
      4: return 16;
      5: return 16;
      6: return 14;
      default: return 12;
    endcase
  endfunction

  function automatic int grp_base(int j);
    int acc = 0;
    for (int i = 0; i < j; i++) acc += grp_size(i);
    return acc;
  endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int N_ROW  = 113,
  parameter int ROW_W  = 36,
  parameter int ADDR_W = 7
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [ROW_W-1:0]                  wr_row_i,
  input  logic                              erase_i,
  output logic [N_ROW-1:0][ROW_W-1:0]       rows_o
);
  logic [N_ROW-1:0][ROW_W-1:0] rows_q;
  logic                        addr_ok;

  assign addr_ok = int'(wr_addr_i) < N_ROW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rows_q <= '0;
    end else if (erase_i) begin
      rows_q <= '0;
    end else if (wr_en_i && addr_ok) begin
      rows_q[wr_addr_i] <= wr_row_i;
    end
  end

  assign rows_o = rows_q;

  a_r9_erase_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (rows_o == '0));

  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !erase_i && addr_ok) |=> (rows_o[$past(wr_addr_i)] == $past(wr_row_i)));

  a_r8_oob_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!erase_i && (!wr_en_i || !addr_ok)) |=> $stable(rows_o));
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_SIG  = 18,
  parameter int N_ROW  = 113,
  localparam int N_LINE = 2 * N_SIG
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_SIG-1:0]             sig_i,
  input  logic [N_ROW-1:0][N_LINE-1:0] rows_i,
  output logic [N_ROW-1:0]             term_o
);
  function automatic logic [N_LINE-1:0] even_mask();
    logic [N_LINE-1:0] m = '0;
    for (int k = 0; k < N_SIG; k++) m[2*k] = 1'b1;
    return m;
  endfunction
  localparam logic [N_LINE-1:0] EVEN = even_mask();

  logic [N_LINE-1:0] lines;

  for (genvar k = 0; k < N_SIG; k++) begin : g_line
    assign lines[2*k]   = sig_i[k];
    assign lines[2*k+1] = ~sig_i[k];
  end

  for (genvar t = 0; t < N_ROW; t++) begin : g_term
    // open connection contributes a constant 1 to the AND
    assign term_o[t] = &(~rows_i[t] | lines);

    a_r3_empty_true: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rows_i[t] == '0) |-> term_o[t]);

    a_r4_pair_false: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(rows_i[t] & (rows_i[t] >> 1) & EVEN)) |-> !term_o[t]);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
  import sop_pkg::*;
#(
  parameter int N_G = N_OUT,
  localparam int N_IN = grp_base(N_G)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  terms_i,
  output logic [N_G-1:0]   sum_o
);
  for (genvar j = 0; j < N_G; j++) begin : g_or
    localparam int B = grp_base(j);
    localparam int S = grp_size(j);
    assign sum_o[j] = |terms_i[B +: S];

    a_r5_first_term_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
      terms_i[B] |-> sum_o[j]);

    a_r5_last_term_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
      terms_i[B+S-1] |-> sum_o[j]);
  end
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
#(
  parameter int N_DED = 10,
  parameter int N_FB  = N_OUT,
  localparam int N_SIG  = N_DED + N_FB,
  localparam int ROW_W  = 2 * N_SIG,
  localparam int ADDR_W = $clog2(N_TERM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_DED-1:0]  ded_i,
  input  logic [N_FB-1:0]   fb_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic              erase_i,
  output logic [N_OUT-1:0]  sum_o,
  output logic [N_OUT-1:0]  oe_o,
  output logic              preset_o,
  output logic              clear_o,
  output logic              clock_o
);
  logic [N_TERM-1:0][ROW_W-1:0] rows;
  logic [N_TERM-1:0]            terms;
  logic [N_SIG-1:0]             sig;

  assign sig = {fb_i, ded_i};

  sop_cfg_store #(.N_ROW(N_TERM), .ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_row_i, .erase_i,
    .rows_o(rows)
  );

  sop_and_plane #(.N_SIG(N_SIG), .N_ROW(N_TERM)) u_and (
    .clk_i, .rst_ni, .sig_i(sig), .rows_i(rows), .term_o(terms)
  );

  sop_or_plane #(.N_G(N_OUT)) u_or (
    .clk_i, .rst_ni, .terms_i(terms[N_SUM-1:0]), .sum_o(sum_o)
  );

  assign oe_o     = terms[ROW_OE +: N_OUT];
  assign preset_o = terms[ROW_PRE];
  assign clear_o  = terms[ROW_CLR];
  assign clock_o  = terms[ROW_CLK];

  a_r6_clear_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rows[ROW_CLR] == '0) |-> clear_o);
endmodule

// File: tb/sop_array_tb.sv
module sop_array_tb_top;
  localparam time TCLK = 10ns;
  localparam logic [35:0] KILL = 36'h3; // ded0 true + complement

  logic clk = 0, rst_ni = 0;
  logic [9:0] ded = '0;
  logic [7:0] fb = '0;
  logic wr_en = 0, erase = 0;
  logic [6:0] wr_addr = '0;
  logic [35:0] wr_row = '0;
  logic [7:0] sum, oe;
  logic pre, clr, ck;
  int total = 0, bad = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  sop_array dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ded_i(ded), .fb_i(fb),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_row_i(wr_row), .erase_i(erase),
    .sum_o(sum), .oe_o(oe), .preset_o(pre), .clear_o(clr), .clock_o(ck)
  );

  function automatic logic [18:0] obs();
    return {ck, clr, pre, oe, sum};
  endfunction

  task automatic chk(string req, logic [18:0] exp);
    total++;
    if (obs() !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, obs(), exp);
    end
  endtask

  task automatic wr(int a, logic [35:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = 7'(a); wr_row = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic kill_all();
    for (int r = 0; r < 113; r++) wr(r, KILL);
  endtask

  task automatic t_reset();
    #1 chk("R10 reset erased", '1);
  endtask

  task automatic t_kill();
    kill_all();
    chk("R4 all rows false", '0);
    ded = 10'h3FF; fb = 8'hFF; #1;
    chk("R4 all rows false ones", '0);
    ded = '0; fb = '0;
  endtask

  task automatic t_and();
    // ded3 true (line 6), fb2 complement (signal 12 -> line 25)
    wr(0, (36'd1 << 6) | (36'd1 << 25));
    ded = '0; fb = '0; #1;
    chk("R2 ded3 low", '0);
    ded[3] = 1; #1;
    chk("R11 R1 ded3 high fb2 low", 19'h1);
    fb[2] = 1; #1;
    chk("R1 fb2 high", '0);
    fb[2] = 0; ded[4] = 1; #1;
    chk("R2 other signal ignored", 19'h1);
    ded = '0; fb = '0;
    wr(0, (36'd1 << 10) | (36'd1 << 11)); // ded5 both lines
    ded[5] = 1; #1;
    chk("R4 pair high", '0);
    ded[5] = 0; #1;
    chk("R4 pair low", '0);
    wr(0, '0);
    ded = 10'h2A5; fb = 8'h5A; #1;
    chk("R3 empty row", 19'h1);
    ded = '0; fb = '0; #1;
    chk("R3 empty row zeros", 19'h1);
    wr(0, KILL);
  endtask

  task automatic t_groups();
    int sz[8] = '{8, 10, 12, 14, 16, 16, 14, 12};
    int base = 0;
    for (int j = 0; j < 8; j++) begin
      wr(base, '0);
      chk($sformatf("R5 group %0d first", j), 19'(1) << j);
      wr(base, KILL);
      wr(base + sz[j] - 1, '0);
      chk($sformatf("R5 group %0d last", j), 19'(1) << j);
      wr(base + sz[j] - 1, KILL);
      base += sz[j];
    end
  endtask

  task automatic t_ctl();
    for (int j = 0; j < 11; j++) begin
      wr(102 + j, '0);
      chk($sformatf("R6 control row %0d", 102 + j), 19'(1) << (8 + j));
      wr(102 + j, KILL);
    end
  endtask

  task automatic t_oob();
    wr(113, '0);
    chk("R8 addr 113", '0);
    wr(127, '0);
    chk("R8 addr 127", '0);
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    wr_en = 1; wr_addr = 7'd110; wr_row = '0;
    #1 chk("R7 before edge", '0);
    @(negedge clk);
    wr_en = 0;
    chk("R7 after edge", 19'h1 << 16);
    wr(110, KILL);
  endtask

  task automatic t_erase();
    @(negedge clk);
    erase = 1; wr_en = 1; wr_addr = 7'd0; wr_row = KILL;
    @(negedge clk);
    erase = 0; wr_en = 0;
    chk("R9 erase beats write", '1);
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(TCLK * 3);
    t_reset();
    @(negedge clk);
    rst_ni = 1;
    t_kill();
    t_and();
    t_groups();
    t_ctl();
    t_oob();
    t_write_timing();
    t_erase();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule